// File: doc/BRIEF.md
# Byte-Lane Latched Bidirectional Transceiver

This block moves 16-bit data between two ports, A and B, in both directions. It never inverts the data. The word is split into two byte lanes. Each lane has its own controls for each direction:

- an active-low enable,
- an active-low load (latch) enable,
- an active-low drive enable.

Tying the lane controls together gives whole-word operation.

Each direction holds one storage register per lane. While the lane is enabled and its load enable is low, the register follows the incoming port. When the load enable goes high, the register keeps the last value it took and ignores later input changes. The stored value is presented on the opposite port. A per-bit drive-enable vector says when the lane actually drives that port. The ports are separate input, output and drive-enable vectors, so no tri-state nets are needed.

The storage is clocked for an FPGA fabric instead of being built from real latches. It has a synchronous active-high reset. Data and drive enables appear one clock after the edge that samples the controls.

Top module: `byte_lane_xcvr`

## Requirements
- R1: On the clock edge after `rst` is high, every stored byte, every output byte and every drive-enable bit is 0.
- R2: Data passes unchanged in value and bit position: bit i of the source port arrives as bit i of the opposite output, for all 16 bits, including all-ones and all-zeros words.
- R3: On an edge where a lane's A-to-B enable and load enable are both low, that lane's stored byte takes the lane's `a_in` byte. `b_out` shows it one clock later.
- R4: On an edge where the load enable is high, the stored byte is kept. After the load enable rises, changes on the source port no longer reach the output.
- R5: On an edge where a lane's enable is high, that lane's stored byte is kept and its drive enables are 0 on the next cycle, whatever the load and drive enables are.
- R6: A lane's eight drive-enable bits are all 1 one clock after an edge where that lane's enable and drive enable are both low, and all 0 otherwise.
- R7: With the drive enable high, the lane does not drive, even while its storage is loading.
- R8: The two byte lanes are independent: the controls of one lane never change the stored data or drive enables of the other.
- R9: The B-to-A direction follows R3 to R7 with its own controls, from `b_in` into `a_out` and `a_oe`.
- R10: Both directions of one lane may be set to drive at once. Each drive-enable vector then follows only its own controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data presented on port A (stored B-to-A bytes) |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data presented on port B (stored A-to-B bytes) |
| b_oe | output | 16 | Per-bit drive enable for port B |
| ab_en_n | input | 2 | Per-lane A-to-B enable, active low |
| ab_le_n | input | 2 | Per-lane A-to-B load enable, active low |
| ab_oe_n | input | 2 | Per-lane A-to-B drive enable, active low |
| ba_en_n | input | 2 | Per-lane B-to-A enable, active low |
| ba_le_n | input | 2 | Per-lane B-to-A load enable, active low |
| ba_oe_n | input | 2 | Per-lane B-to-A drive enable, active low |

## Verification
Every result of this block, stored data and drive enables alike, is due exactly one rising edge after the edge that samples the controls and data. The bench changes inputs only on falling edges. It updates its reference model at the rising edge, using the inputs held steady there. It compares the outputs at the following falling edge, so each comparison sits one register stage after its stimulus. Hold checks change the source data only after the edge where the load enable is already high. They then expect the earlier byte on the next falling edge.

// File: rtl/byte_lane_xcvr_pkg.sv
package byte_lane_xcvr_pkg;

  // Active-low controls of one direction of one byte lane.
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } xfer_ctl_t;

  // Decoded actions for one direction of one byte lane.
  typedef struct packed {
    logic load;
    logic drive;
  } xfer_act_t;

endpackage

// File: rtl/xcvr_ctl_decode.sv
module xcvr_ctl_decode
  import byte_lane_xcvr_pkg::*;
(
  input  xfer_ctl_t ctl,
  output xfer_act_t act
);

  // The enable gates both loading and driving.
  always_comb begin
    act.load  = ~ctl.en_n & ~ctl.le_n;
    act.drive = ~ctl.en_n & ~ctl.oe_n;
  end

endmodule

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         drive,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out,
  output logic [W-1:0] q_oe
);

  // Clocked stand-in for a transparent latch: it follows d_in while load is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_out <= '0;
      q_oe  <= '0;
    end else begin
      if (load) begin
        q_out <= d_in;
      end
      q_oe <= {W{drive}};
    end
  end

endmodule

// File: rtl/byte_lane_xcvr.sv
module byte_lane_xcvr
  import byte_lane_xcvr_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*LANE_W-1:0]   a_in,
  output logic [LANES*LANE_W-1:0]   a_out,
  output logic [LANES*LANE_W-1:0]   a_oe,
  input  logic [LANES*LANE_W-1:0]   b_in,
  output logic [LANES*LANE_W-1:0]   b_out,
  output logic [LANES*LANE_W-1:0]   b_oe,
  input  logic [LANES-1:0]          ab_en_n,
  input  logic [LANES-1:0]          ab_le_n,
  input  logic [LANES-1:0]          ab_oe_n,
  input  logic [LANES-1:0]          ba_en_n,
  input  logic [LANES-1:0]          ba_le_n,
  input  logic [LANES-1:0]          ba_oe_n
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LO = g * LANE_W;

    xfer_ctl_t ab_ctl;
    xfer_ctl_t ba_ctl;
    xfer_act_t ab_act;
    xfer_act_t ba_act;

    assign ab_ctl = {ab_en_n[g], ab_le_n[g], ab_oe_n[g]};
    assign ba_ctl = {ba_en_n[g], ba_le_n[g], ba_oe_n[g]};

    xcvr_ctl_decode u_ab_dec (.ctl(ab_ctl), .act(ab_act));
    xcvr_ctl_decode u_ba_dec (.ctl(ba_ctl), .act(ba_act));

    // A-to-B: port A bytes are stored and presented on port B.
    xcvr_lane_store #(.W(LANE_W)) u_ab_store (
      .clk   (clk),
      .rst   (rst),
      .load  (ab_act.load),
      .drive (ab_act.drive),
      .d_in  (a_in[LO +: LANE_W]),
      .q_out (b_out[LO +: LANE_W]),
      .q_oe  (b_oe[LO +: LANE_W])
    );

    // B-to-A: port B bytes are stored and presented on port A.
    xcvr_lane_store #(.W(LANE_W)) u_ba_store (
      .clk   (clk),
      .rst   (rst),
      .load  (ba_act.load),
      .drive (ba_act.drive),
      .d_in  (b_in[LO +: LANE_W]),
      .q_out (a_out[LO +: LANE_W]),
      .q_oe  (a_oe[LO +: LANE_W])
    );
  end

endmodule

// File: rtl/byte_lane_xcvr_chk.sv
module byte_lane_xcvr_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES*LANE_W-1:0] a_oe,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES*LANE_W-1:0] b_oe,
  input logic [LANES-1:0]        ab_en_n,
  input logic [LANES-1:0]        ab_le_n,
  input logic [LANES-1:0]        ab_oe_n,
  input logic [LANES-1:0]        ba_en_n,
  input logic [LANES-1:0]        ba_le_n,
  input logic [LANES-1:0]        ba_oe_n
);

  // Set once a full non-reset cycle lies behind, so $past never reaches into reset.
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_out == '0 && b_out == '0 && a_oe == '0 && b_oe == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam int unsigned LO = g * LANE_W;

    // R3
    ab_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(~ab_en_n[g] & ~ab_le_n[g])) |-> (b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W])));

    // R4
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(ab_en_n[g] | ab_le_n[g])) |-> $stable(b_out[LO +: LANE_W]));

    // R5
    ab_off_chk: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(ab_en_n[g])) |-> (b_oe[LO +: LANE_W] == '0));

    // R6
    ab_drive_chk: assert property (@(posedge clk) disable iff (rst)
      primed |-> (b_oe[LO +: LANE_W] == {LANE_W{$past(~ab_en_n[g] & ~ab_oe_n[g])}}));

    // R9
    ba_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(~ba_en_n[g] & ~ba_le_n[g])) |-> (a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W])));

    // R9
    ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(ba_en_n[g] | ba_le_n[g])) |-> $stable(a_out[LO +: LANE_W]));

    // R9
    ba_drive_chk: assert property (@(posedge clk) disable iff (rst)
      primed |-> (a_oe[LO +: LANE_W] == {LANE_W{$past(~ba_en_n[g] & ~ba_oe_n[g])}}));
  end

endmodule

bind byte_lane_xcvr byte_lane_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
  .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
  .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
);

// File: tb/byte_lane_xcvr_tb.sv
module byte_lane_xcvr_tb;
  localparam int unsigned LW = 8;
  localparam int unsigned NL = 2;
  localparam int unsigned BW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [BW-1:0] a_out, a_oe, b_out, b_oe;
  logic [NL-1:0] ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NL-1:0] ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;

  int  errs = 0, checks = 0, overlaps = 0;
  bit  done = 1'b0;

  logic [LW-1:0] m_b [NL];
  logic [LW-1:0] m_a [NL];
  logic          m_boe [NL];
  logic          m_aoe [NL];

  byte_lane_xcvr #(.LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  function automatic logic [LW-1:0] lane_of(input logic [BW-1:0] v, input int l);
    return v[l*LW +: LW];
  endfunction

  task automatic chk(input string tag, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // One clock: update the model at the rising edge, compare at the falling edge.
  task automatic cycle(input string tag);
    @(posedge clk);
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        m_b[l] = '0; m_a[l] = '0; m_boe[l] = 1'b0; m_aoe[l] = 1'b0;
      end else begin
        if (!ab_en_n[l] && !ab_le_n[l]) m_b[l] = lane_of(a_in, l);
        if (!ba_en_n[l] && !ba_le_n[l]) m_a[l] = lane_of(b_in, l);
        m_boe[l] = !ab_en_n[l] && !ab_oe_n[l];
        m_aoe[l] = !ba_en_n[l] && !ba_oe_n[l];
      end
    end
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk(tag, $sformatf("b_out lane%0d", l), lane_of(b_out, l), m_b[l]);
      chk(tag, $sformatf("b_oe lane%0d", l),  lane_of(b_oe, l),  {LW{m_boe[l]}});
      chk(tag, $sformatf("a_out lane%0d", l), lane_of(a_out, l), m_a[l]);
      chk(tag, $sformatf("a_oe lane%0d", l),  lane_of(a_oe, l),  {LW{m_aoe[l]}});
      if (m_boe[l] && m_aoe[l]) overlaps++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cycle("R1"); cycle("R1");
    rst = 1'b0;
    cycle("R1");
    chk("R1", "b_out lane0 after reset", lane_of(b_out, 0), 8'h00);
    chk("R1", "a_oe lane1 after reset", lane_of(a_oe, 1), 8'h00);

    // R3 / R2: transparent loading, several patterns
    ab_en_n = '0; ab_le_n = '0; ab_oe_n = '0; a_in = 16'hA5C3;
    cycle("R3");
    chk("R2", "b_out lane0", lane_of(b_out, 0), 8'hC3);
    chk("R2", "b_out lane1", lane_of(b_out, 1), 8'hA5);
    a_in = 16'hFFFF; cycle("R2");
    a_in = 16'h0000; cycle("R2");
    a_in = 16'h3C5A; cycle("R3");

    // R4: capture on load-enable rise, later data ignored
    ab_le_n = '1; cycle("R4");
    a_in = 16'hFFFF; cycle("R4");
    chk("R4", "held lane0", lane_of(b_out, 0), 8'h5A);
    chk("R4", "held lane1", lane_of(b_out, 1), 8'h3C);

    // R7: drive off while loading
    ab_oe_n = '1; ab_le_n = '0; a_in = 16'h1234; cycle("R7");
    chk("R7", "b_oe lane0", lane_of(b_oe, 0), 8'h00);
    chk("R7", "b_out lane0 loaded", lane_of(b_out, 0), 8'h34);

    // R5: enable high overrides load and drive
    ab_en_n = '1; ab_le_n = '0; ab_oe_n = '0; a_in = 16'h9999; cycle("R5");
    chk("R5", "b_oe lane1", lane_of(b_oe, 1), 8'h00);
    chk("R5", "b_out lane1 held", lane_of(b_out, 1), 8'h12);

    // R6: drive held value
    ab_en_n = '0; ab_le_n = '1; ab_oe_n = '0; cycle("R6");
    chk("R6", "b_oe lane0", lane_of(b_oe, 0), 8'hFF);
    chk("R6", "b_out lane0", lane_of(b_out, 0), 8'h34);

    // R8: lane 0 enabled, lane 1 disabled
    ab_en_n = 2'b10; ab_le_n = '0; a_in = 16'h7788; cycle("R8");
    chk("R8", "lane0 loaded", lane_of(b_out, 0), 8'h88);
    chk("R8", "lane1 untouched", lane_of(b_out, 1), 8'h12);
    chk("R8", "lane1 not driving", lane_of(b_oe, 1), 8'h00);

    // R9: B-to-A direction
    ab_le_n = '1;
    ba_en_n = '0; ba_le_n = '0; ba_oe_n = '0; b_in = 16'hBEEF; cycle("R9");
    ba_le_n = '1; cycle("R9");
    b_in = 16'h0000; cycle("R9");
    chk("R9", "a_out lane0", lane_of(a_out, 0), 8'hEF);
    chk("R9", "a_out lane1", lane_of(a_out, 1), 8'hBE);
    chk("R9", "a_oe lane1", lane_of(a_oe, 1), 8'hFF);

    // R10: both directions of lane 0 drive at once (bus contention noted)
    cycle("R10");
    chk("R10", "b_oe lane0", lane_of(b_oe, 0), 8'hFF);
    chk("R10", "a_oe lane0", lane_of(a_oe, 0), 8'hFF);
    if (overlaps > 0) $display("note: %0d lane-cycles with both ports driven (bus contention)", overlaps);

    // R8: random mix of controls and data
    for (int i = 0; i < 400; i++) begin
      a_in = BW'($urandom); b_in = BW'($urandom);
      ab_en_n = NL'($urandom); ab_le_n = NL'($urandom); ab_oe_n = NL'($urandom);
      ba_en_n = NL'($urandom); ba_le_n = NL'($urandom); ba_oe_n = NL'($urandom);
      cycle("R8");
    end

    // R1: reset again clears everything
    rst = 1'b1; cycle("R1");
    chk("R1", "b_out lane1 re-reset", lane_of(b_out, 1), 8'h00);
    rst = 1'b0;

    done = 1'b1;
    report();
    $finish;
  end

endmodule